// File: doc/BRIEF.md
# CPU Power Domain Sequencer

This block steps one CPU power domain between four power states: ON-ACTIVE, ON-INACTIVE, RETENTION and OFF. Software sets a target low-power state, chooses whether logic is kept or switched off in RETENTION, and picks a clock-transition mode. That mode decides whether the CPU's wait-for-interrupt signal starts a sleep, whether sleep is blocked, or whether a software-forced wake-up is in force. Wake-up events bring the domain back to ON-ACTIVE.

The clock stop, the logic power switch and the L1 memory array are outside the block. Each one is driven through a level request and a level acknowledge, and a step ends when the acknowledge matches the request. A sleep runs clock, then logic, then memory. A wake runs the same three steps in reverse order.

The block also keeps context bookkeeping that a warm reset does not touch. It holds write-1-to-clear flags for lost L1 memory contents and lost flip-flop state, and a record of the deepest low-power state entered since software last re-armed it. It also reports the current state, a busy flag, the memory and logic status and standby, and it drives the core reset from a software warm-reset bit and the warm reset input.

Top module: `cpu_pd_sequencer`

## Requirements
- R1: After a cold reset (`rst_n` low at a clock edge) the block reports state 3, busy 0, L1 status 3, logic status 1, standby 0, both lost flags 0 and last-state 3, and it requests clock running, logic powered and memory 3.
- R2: Power states use 2 bits: 0 OFF, 1 RETENTION, 2 ON-INACTIVE, 3 ON-ACTIVE. A sleep to target 2 stops only the clock and ends with state 2, standby 1, logic status 1 and L1 status 3.
- R3: A sleep to target 1 ends in state 1 with L1 status 1. If logic-keep is 1, logic status stays 1 and no flip-flop loss is flagged. If logic-keep is 0, logic status becomes 0 and the flip-flop lost flag is set.
- R4: A sleep to target 0 ends in state 0 with logic status 0 and L1 status 0, and it sets both the L1 lost flag and the flip-flop lost flag. L1 status uses 0 off, 1 retained, 3 on.
- R5: A sleep changes the logic request only after the clock acknowledge reads stopped, and the memory request only after the logic acknowledge matches. A wake raises the clock request only after memory reads 3 and logic reads powered.
- R6: Busy reads 1 from the cycle after a transition starts until its last step finishes. The reported state does not change while busy is 1.
- R7: With mode 0 or mode 1, wait-for-interrupt starts no sleep. A wake input still returns a sleeping domain to state 3.
- R8: With mode 2, a sleeping domain wakes to state 3 without any wake input, and wait-for-interrupt starts no sleep.
- R9: With mode 3 and no wake input, wait-for-interrupt starts a sleep only when the target is not 3. With target 3 the domain stays in state 3 and never goes busy.
- R10: Each completed sleep sets last-state to the smaller of its current value and the state entered. A re-arm pulse sets it to 3. A wake does not change it.
- R11: A clear pulse resets its own lost flag and leaves the other flag unchanged. A set condition in the same cycle wins over the clear.
- R12: The core reset output is high while the software warm-reset bit is 1 or the warm reset input is low, and while it is high the flip-flop lost flag is set. A warm reset leaves the state, the L1 status, the L1 lost flag and last-state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, synchronous, active low |
| warm_rst_n_i | input | 1 | Warm reset, active low; affects only core reset and the flip-flop lost flag |
| tgt_state_i | input | 2 | Target low-power state |
| logic_keep_i | input | 1 | 1 keeps logic powered in RETENTION |
| clk_mode_i | input | 2 | 0 no sleep, 1 reserved (no sleep), 2 forced wake, 3 automatic sleep on wait-for-interrupt |
| sw_core_rst_i | input | 1 | Software warm-reset bit |
| wfi_i | input | 1 | CPU wait-for-interrupt |
| wake_i | input | 1 | Wake-up event |
| clr_l1_lost_i | input | 1 | Write-1 pulse that clears the L1 lost flag |
| clr_dff_lost_i | input | 1 | Write-1 pulse that clears the flip-flop lost flag |
| lps_rearm_i | input | 1 | Pulse that sets last-state to 3 |
| clk_run_o | output | 1 | Clock-run request |
| clk_run_ack_i | input | 1 | Clock-run acknowledge |
| logic_pwr_o | output | 1 | Logic power request |
| logic_pwr_ack_i | input | 1 | Logic power acknowledge |
| mem_req_o | output | 2 | Memory state request (0 off, 1 retain, 3 on) |
| mem_ack_i | input | 2 | Memory state acknowledge |
| cur_state_o | output | 2 | Current settled power state |
| busy_o | output | 1 | Transition in progress |
| l1_state_o | output | 2 | L1 memory status |
| logic_state_o | output | 1 | Logic status, 1 powered |
| standby_o | output | 1 | 1 when the domain clock is stopped |
| last_lp_state_o | output | 2 | Deepest state entered since re-arm |
| l1_lost_o | output | 1 | L1 contents lost flag |
| dff_lost_o | output | 1 | Flip-flop state lost flag |
| core_rst_o | output | 1 | CPU core reset |

## Verification
The block has no parameters, so the bench builds it as it is. Its own knob is the latency of the acknowledge responders for the clock, logic and memory handshakes, which it sweeps from one to four cycles. At every latency it runs each sleep target with both logic-keep values and rotates among the three wake methods. This exposes the step order and the busy window at short and at long handshakes. Separate passes cover the blocked modes, target 3, the running-minimum and re-arm behaviour of last-state, and warm and software resets applied while the domain is in RETENTION.

// File: rtl/pd_seq_pkg.sv
// Shared encodings for the CPU power domain sequencer.
// Assumes 2-bit power-state, memory-state and clock-mode fields.
package pd_seq_pkg;

    localparam int PS_W = 2;
    localparam int MS_W = 2;
    localparam int CM_W = 2;

    localparam logic [PS_W-1:0] PS_OFF   = 2'd0;
    localparam logic [PS_W-1:0] PS_RET   = 2'd1;
    localparam logic [PS_W-1:0] PS_INACT = 2'd2;
    localparam logic [PS_W-1:0] PS_ACT   = 2'd3;

    localparam logic [MS_W-1:0] MEM_OFF  = 2'd0;
    localparam logic [MS_W-1:0] MEM_RET  = 2'd1;
    localparam logic [MS_W-1:0] MEM_ON   = 2'd3;

    localparam logic [CM_W-1:0] CM_NOSLEEP = 2'd0;
    localparam logic [CM_W-1:0] CM_FORCE   = 2'd2;
    localparam logic [CM_W-1:0] CM_AUTO    = 2'd3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SLP_CLK,
        SQ_SLP_LOGIC,
        SQ_SLP_MEM,
        SQ_WK_MEM,
        SQ_WK_LOGIC,
        SQ_WK_CLK
    } seq_e;

endpackage

// File: rtl/pd_wake_ctrl.sv
// Turns the clock-transition mode, wait-for-interrupt and wake inputs into
// sleep and wake decisions. Assumes mode 1 is reserved and acts as no-sleep.
module pd_wake_ctrl
    import pd_seq_pkg::*;
(
    input  logic [CM_W-1:0] mode_i,
    input  logic            wfi_i,
    input  logic            wake_i,
    input  logic [PS_W-1:0] tgt_i,
    output logic            sleep_go_o,
    output logic            wake_go_o
);

    // Decide whether a sleep may start and whether a wake is requested.
    always_comb begin
        sleep_go_o = (mode_i == CM_AUTO) && wfi_i && !wake_i && (tgt_i != PS_ACT);
        wake_go_o  = wake_i || (mode_i == CM_FORCE);
    end

endmodule

// File: rtl/pd_seq_fsm.sv
// Sequencer for clock, logic and memory handshakes. Every step sets a
// level request and completes on the first edge where the acknowledge
// equals it. Sleep runs clock, logic, memory; wake runs the reverse.
// Assumes acknowledges only move toward the current request.
module pd_seq_fsm
    import pd_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_go_i,
    input  logic            wake_go_i,
    input  logic [PS_W-1:0] tgt_i,
    input  logic            keep_i,
    input  logic            clk_ack_i,
    input  logic            logic_ack_i,
    input  logic [MS_W-1:0] mem_ack_i,
    output logic            clk_req_o,
    output logic            logic_req_o,
    output logic [MS_W-1:0] mem_req_o,
    output logic [PS_W-1:0] cur_state_o,
    output logic            busy_o,
    output logic [MS_W-1:0] l1_state_o,
    output logic            logic_on_o,
    output logic            clk_on_o,
    output logic            entry_o,
    output logic [PS_W-1:0] entry_state_o,
    output logic            logic_lost_o
);

    seq_e            st_q;
    logic            clk_req_q;
    logic            logic_req_q;
    logic [MS_W-1:0] mem_req_q;
    logic [PS_W-1:0] cur_q;
    logic [PS_W-1:0] tgt_q;
    logic            keep_q;
    logic [MS_W-1:0] l1_q;
    logic            logic_on_q;
    logic            clk_on_q;
    logic            clk_match;
    logic            logic_match;
    logic            mem_match;

    // Handshake completion flags.
    always_comb begin
        clk_match   = (clk_ack_i == clk_req_q);
        logic_match = (logic_ack_i == logic_req_q);
        mem_match   = (mem_ack_i == mem_req_q);
    end

    // Step through the sleep and wake sequences.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= SQ_IDLE;
            clk_req_q   <= 1'b1;
            logic_req_q <= 1'b1;
            mem_req_q   <= MEM_ON;
            cur_q       <= PS_ACT;
            tgt_q       <= PS_ACT;
            keep_q      <= 1'b1;
            l1_q        <= MEM_ON;
            logic_on_q  <= 1'b1;
            clk_on_q    <= 1'b1;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (cur_q == PS_ACT && sleep_go_i) begin
                        tgt_q     <= tgt_i;
                        keep_q    <= keep_i;
                        clk_req_q <= 1'b0;
                        st_q      <= SQ_SLP_CLK;
                    end else if (cur_q != PS_ACT && wake_go_i) begin
                        mem_req_q <= MEM_ON;
                        st_q      <= SQ_WK_MEM;
                    end
                end
                SQ_SLP_CLK: begin
                    if (clk_match) begin
                        clk_on_q <= 1'b0;
                        if (tgt_q == PS_INACT) begin
                            cur_q <= PS_INACT;
                            st_q  <= SQ_IDLE;
                        end else begin
                            logic_req_q <= (tgt_q == PS_RET) && keep_q;
                            st_q        <= SQ_SLP_LOGIC;
                        end
                    end
                end
                SQ_SLP_LOGIC: begin
                    if (logic_match) begin
                        logic_on_q <= logic_req_q;
                        mem_req_q  <= (tgt_q == PS_RET) ? MEM_RET : MEM_OFF;
                        st_q       <= SQ_SLP_MEM;
                    end
                end
                SQ_SLP_MEM: begin
                    if (mem_match) begin
                        l1_q  <= mem_req_q;
                        cur_q <= tgt_q;
                        st_q  <= SQ_IDLE;
                    end
                end
                SQ_WK_MEM: begin
                    if (mem_match) begin
                        l1_q        <= MEM_ON;
                        logic_req_q <= 1'b1;
                        st_q        <= SQ_WK_LOGIC;
                    end
                end
                SQ_WK_LOGIC: begin
                    if (logic_match) begin
                        logic_on_q <= 1'b1;
                        clk_req_q  <= 1'b1;
                        st_q       <= SQ_WK_CLK;
                    end
                end
                SQ_WK_CLK: begin
                    if (clk_match) begin
                        clk_on_q <= 1'b1;
                        cur_q    <= PS_ACT;
                        st_q     <= SQ_IDLE;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Sleep-entry and logic-loss events for the context tracker.
    always_comb begin
        entry_o       = ((st_q == SQ_SLP_CLK) && clk_match && (tgt_q == PS_INACT))
                     || ((st_q == SQ_SLP_MEM) && mem_match);
        entry_state_o = tgt_q;
        logic_lost_o  = (st_q == SQ_SLP_LOGIC) && logic_match && !logic_req_q;
    end

    assign clk_req_o   = clk_req_q;
    assign logic_req_o = logic_req_q;
    assign mem_req_o   = mem_req_q;
    assign cur_state_o = cur_q;
    assign busy_o      = (st_q != SQ_IDLE);
    assign l1_state_o  = l1_q;
    assign logic_on_o  = logic_on_q;
    assign clk_on_o    = clk_on_q;

    // R5
    logic_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(logic_req_q) |-> (!clk_ack_i && !clk_req_q));

    // R5
    mem_after_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mem_req_q) && mem_req_q != MEM_ON) |-> (logic_ack_i == logic_req_q));

    // R5
    clk_wakes_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_req_q) |-> (logic_ack_i && mem_ack_i == MEM_ON));

    // R6
    state_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != SQ_IDLE) |-> $stable(cur_q));

endmodule

// File: rtl/pd_ctx_track.sv
// Context bookkeeping: L1 and flip-flop lost flags (write-1-to-clear, set
// wins) and the deepest low-power state entered. Reset only by cold reset.
module pd_ctx_track
    import pd_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_i,
    input  logic [PS_W-1:0] entry_state_i,
    input  logic            logic_lost_i,
    input  logic            core_rst_i,
    input  logic [MS_W-1:0] l1_state_i,
    input  logic            clr_l1_i,
    input  logic            clr_dff_i,
    input  logic            rearm_i,
    output logic            l1_lost_o,
    output logic            dff_lost_o,
    output logic [PS_W-1:0] lps_o
);

    logic            l1_lost_q;
    logic            dff_lost_q;
    logic [PS_W-1:0] lps_q;

    // Track lost flags and the last low-power state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l1_lost_q  <= 1'b0;
            dff_lost_q <= 1'b0;
            lps_q      <= PS_ACT;
        end else begin
            if (entry_i && entry_state_i == PS_OFF) begin
                l1_lost_q <= 1'b1;
            end else if (clr_l1_i) begin
                l1_lost_q <= 1'b0;
            end
            if (logic_lost_i || core_rst_i) begin
                dff_lost_q <= 1'b1;
            end else if (clr_dff_i) begin
                dff_lost_q <= 1'b0;
            end
            if (entry_i && entry_state_i < lps_q) begin
                lps_q <= entry_state_i;
            end else if (rearm_i) begin
                lps_q <= PS_ACT;
            end
        end
    end

    assign l1_lost_o  = l1_lost_q;
    assign dff_lost_o = dff_lost_q;
    assign lps_o      = lps_q;

    // R4
    l1_lost_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l1_lost_q) |-> (l1_state_i == MEM_OFF));

    // R10
    lps_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lps_q) |-> ((lps_q < $past(lps_q)) || (lps_q == PS_ACT && $past(rearm_i))));

    // R12
    rst_marks_dff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_i |=> dff_lost_q);

endmodule

// File: rtl/cpu_pd_sequencer.sv
// Top of the CPU power domain sequencer: mode decode, handshake sequencer
// and context tracker. Assumes external clock, logic and memory agents
// answer with level acknowledges that follow their requests.
module cpu_pd_sequencer
    import pd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst_n_i,
    input  logic [1:0] tgt_state_i,
    input  logic       logic_keep_i,
    input  logic [1:0] clk_mode_i,
    input  logic       sw_core_rst_i,
    input  logic       wfi_i,
    input  logic       wake_i,
    input  logic       clr_l1_lost_i,
    input  logic       clr_dff_lost_i,
    input  logic       lps_rearm_i,
    output logic       clk_run_o,
    input  logic       clk_run_ack_i,
    output logic       logic_pwr_o,
    input  logic       logic_pwr_ack_i,
    output logic [1:0] mem_req_o,
    input  logic [1:0] mem_ack_i,
    output logic [1:0] cur_state_o,
    output logic       busy_o,
    output logic [1:0] l1_state_o,
    output logic       logic_state_o,
    output logic       standby_o,
    output logic [1:0] last_lp_state_o,
    output logic       l1_lost_o,
    output logic       dff_lost_o,
    output logic       core_rst_o
);

    logic            sleep_go;
    logic            wake_go;
    logic            clk_on;
    logic            entry;
    logic [PS_W-1:0] entry_state;
    logic            logic_lost;

    // Core reset follows the software bit and the warm reset input.
    assign core_rst_o = sw_core_rst_i || !warm_rst_n_i;
    assign standby_o  = !clk_on;

    pd_wake_ctrl u_wake (
        .mode_i     (clk_mode_i),
        .wfi_i      (wfi_i),
        .wake_i     (wake_i),
        .tgt_i      (tgt_state_i),
        .sleep_go_o (sleep_go),
        .wake_go_o  (wake_go)
    );

    pd_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_go_i    (sleep_go),
        .wake_go_i     (wake_go),
        .tgt_i         (tgt_state_i),
        .keep_i        (logic_keep_i),
        .clk_ack_i     (clk_run_ack_i),
        .logic_ack_i   (logic_pwr_ack_i),
        .mem_ack_i     (mem_ack_i),
        .clk_req_o     (clk_run_o),
        .logic_req_o   (logic_pwr_o),
        .mem_req_o     (mem_req_o),
        .cur_state_o   (cur_state_o),
        .busy_o        (busy_o),
        .l1_state_o    (l1_state_o),
        .logic_on_o    (logic_state_o),
        .clk_on_o      (clk_on),
        .entry_o       (entry),
        .entry_state_o (entry_state),
        .logic_lost_o  (logic_lost)
    );

    pd_ctx_track u_ctx (
        .clk           (clk),
        .rst_n         (rst_n),
        .entry_i       (entry),
        .entry_state_i (entry_state),
        .logic_lost_i  (logic_lost),
        .core_rst_i    (core_rst_o),
        .l1_state_i    (l1_state_o),
        .clr_l1_i      (clr_l1_lost_i),
        .clr_dff_i     (clr_dff_lost_i),
        .rearm_i       (lps_rearm_i),
        .l1_lost_o     (l1_lost_o),
        .dff_lost_o    (dff_lost_o),
        .lps_o         (last_lp_state_o)
    );

    // R7
    sleep_needs_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_run_o) |-> ($past(clk_mode_i) == CM_AUTO && $past(wfi_i)));

endmodule

// File: tb/test_cpu_pd_sequencer.sv
`timescale 1ns/1ps
module test_cpu_pd_sequencer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       warm_rst_n;
    logic [1:0] tgt;
    logic       keep;
    logic [1:0] mode;
    logic       sw_rst;
    logic       wfi;
    logic       wake;
    logic       clr_l1;
    logic       clr_dff;
    logic       rearm;
    logic       clk_run;
    logic       clk_ack;
    logic       logic_pwr;
    logic       logic_ack;
    logic [1:0] mem_req;
    logic [1:0] mem_ack;
    logic [1:0] cur_state;
    logic       busy;
    logic [1:0] l1_state;
    logic       logic_state;
    logic       standby;
    logic [1:0] lps;
    logic       l1_lost;
    logic       dff_lost;
    logic       core_rst;

    int errors = 0;
    int checks = 0;
    int lat = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cpu_pd_sequencer i_cpu_pd_sequencer (
        .clk             (clk),
        .rst_n           (rst_n),
        .warm_rst_n_i    (warm_rst_n),
        .tgt_state_i     (tgt),
        .logic_keep_i    (keep),
        .clk_mode_i      (mode),
        .sw_core_rst_i   (sw_rst),
        .wfi_i           (wfi),
        .wake_i          (wake),
        .clr_l1_lost_i   (clr_l1),
        .clr_dff_lost_i  (clr_dff),
        .lps_rearm_i     (rearm),
        .clk_run_o       (clk_run),
        .clk_run_ack_i   (clk_ack),
        .logic_pwr_o     (logic_pwr),
        .logic_pwr_ack_i (logic_ack),
        .mem_req_o       (mem_req),
        .mem_ack_i       (mem_ack),
        .cur_state_o     (cur_state),
        .busy_o          (busy),
        .l1_state_o      (l1_state),
        .logic_state_o   (logic_state),
        .standby_o       (standby),
        .last_lp_state_o (lps),
        .l1_lost_o       (l1_lost),
        .dff_lost_o      (dff_lost),
        .core_rst_o      (core_rst)
    );

    // Handshake responders: acknowledge follows the request after lat+1 edges.
    int c_cnt = 0;
    int l_cnt = 0;
    int m_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            clk_ack <= 1'b1; logic_ack <= 1'b1; mem_ack <= 2'd3;
            c_cnt <= 0; l_cnt <= 0; m_cnt <= 0;
        end else begin
            if (clk_ack != clk_run) begin
                if (c_cnt >= lat) begin clk_ack <= clk_run; c_cnt <= 0; end
                else c_cnt <= c_cnt + 1;
            end
            if (logic_ack != logic_pwr) begin
                if (l_cnt >= lat) begin logic_ack <= logic_pwr; l_cnt <= 0; end
                else l_cnt <= l_cnt + 1;
            end
            if (mem_ack != mem_req) begin
                if (m_cnt >= lat) begin mem_ack <= mem_req; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Order monitor for the handshake sequence (R5).
    logic       p_logic = 1'b1;
    logic       p_clk = 1'b1;
    logic [1:0] p_mem = 2'd3;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (p_logic && !logic_pwr) chk("R5 logic off after clk ack", clk_ack, 0);
            if (!p_logic && logic_pwr) chk("R5 logic on after mem ack", mem_ack, 3);
            if (!p_clk && clk_run) chk("R5 clk on last", {30'd0, logic_ack, mem_ack == 2'd3}, 3);
            if (p_mem != mem_req && mem_req != 2'd3)
                chk("R5 mem after logic ack", logic_ack, logic_pwr);
            p_logic = logic_pwr;
            p_clk   = clk_run;
            p_mem   = mem_req;
        end
    end

    task automatic wait_idle(input string tag);
        logic [1:0] st0 = cur_state;
        int n = 0;
        while (busy && n < 100) begin
            @(negedge clk);
            n++;
            if (busy && cur_state != st0) chk({tag, " R6 state held"}, cur_state, st0);
        end
        chk({tag, " R6 busy ends"}, busy, 0);
    endtask

    task automatic do_sleep(input logic [1:0] t, input logic k);
        tgt = t; keep = k; mode = 2'd3; wfi = 1'b1;
        @(negedge clk);
        chk("R6 busy after sleep start", busy, 1);
        wait_idle("sleep");
        wfi = 1'b0;
    endtask

    task automatic do_wake(input int how);
        case (how)
            0: begin mode = 2'd3; wake = 1'b1; end
            1: begin mode = 2'd2; end
            default: begin mode = 2'd0; wake = 1'b1; end
        endcase
        @(negedge clk);
        chk(how == 1 ? "R8 forced wake starts" : "R7 wake starts", busy, 1);
        wake = 1'b0; mode = 2'd3;
        wait_idle("wake");
        chk("R7 R8 awake state", cur_state, 3);
    endtask

    task automatic pulse_clear(input logic a, input logic b, input logic r);
        clr_l1 = a; clr_dff = b; rearm = r;
        @(negedge clk);
        clr_l1 = 1'b0; clr_dff = 1'b0; rearm = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; warm_rst_n = 1'b1; tgt = 2'd3; keep = 1'b0; mode = 2'd0;
        sw_rst = 1'b0; wfi = 1'b0; wake = 1'b0; clr_l1 = 1'b0; clr_dff = 1'b0; rearm = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", cur_state, 3);
        chk("R1 busy", busy, 0);
        chk("R1 l1", l1_state, 3);
        chk("R1 logic", logic_state, 1);
        chk("R1 standby", standby, 0);
        chk("R1 lost flags", {l1_lost, dff_lost}, 0);
        chk("R1 lps", lps, 3);
        chk("R1 requests", {clk_run, logic_pwr, mem_req}, 15);

        // Sweep latency x target x logic-keep, rotating wake method.
        for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int t = 0; t < 3; t++) begin
                for (int k = 0; k < 2; k++) begin
                    int exp_l1;
                    int exp_lg;
                    pulse_clear(1'b1, 1'b1, 1'b1);
                    chk("R11 flags cleared", {l1_lost, dff_lost}, 0);
                    chk("R10 rearmed", lps, 3);
                    do_sleep(t[1:0], k[0]);
                    exp_l1 = (t == 2) ? 3 : (t == 1) ? 1 : 0;
                    exp_lg = (t == 2) ? 1 : (t == 1) ? k : 0;
                    chk(t == 2 ? "R2 state" : t == 1 ? "R3 state" : "R4 state", cur_state, t);
                    chk(t == 2 ? "R2 l1" : t == 1 ? "R3 l1" : "R4 l1", l1_state, exp_l1);
                    chk(t == 2 ? "R2 logic" : t == 1 ? "R3 logic" : "R4 logic", logic_state, exp_lg);
                    chk("R2 standby", standby, 1);
                    chk("R10 lps after entry", lps, t);
                    chk("R4 l1 lost", l1_lost, (t == 0) ? 1 : 0);
                    chk("R3 dff lost", dff_lost, (exp_lg == 0) ? 1 : 0);
                    do_wake((t + k + l) % 3);
                    chk("R7 l1 on", l1_state, 3);
                    chk("R7 logic on", logic_state, 1);
                    chk("R2 standby off", standby, 0);
                    chk("R10 lps kept over wake", lps, t);
                    chk("R4 l1 lost kept", l1_lost, (t == 0) ? 1 : 0);
                end
            end
        end

        // R11 clear one flag only, both set after OFF entry.
        lat = 1;
        do_sleep(2'd0, 1'b0);
        do_wake(0);
        pulse_clear(1'b1, 1'b0, 1'b0);
        chk("R11 l1 cleared", l1_lost, 0);
        chk("R11 dff untouched", dff_lost, 1);
        pulse_clear(1'b0, 1'b1, 1'b0);
        chk("R11 dff cleared", dff_lost, 0);

        // R9 target 3 with wfi in auto mode: no transition.
        tgt = 2'd3; mode = 2'd3; wfi = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9 no busy", busy, 0);
        end
        chk("R9 stays active", cur_state, 3);
        // R9 wake held high blocks sleep too.
        tgt = 2'd1; wake = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 wake blocks sleep", {busy, cur_state}, 3);
        wake = 1'b0;

        // R7 modes 0 and 1, R8 mode 2: wfi starts nothing.
        for (int m = 0; m < 3; m++) begin
            mode = m[1:0]; tgt = 2'd1; wfi = 1'b1;
            repeat (6) @(negedge clk);
            chk(m == 2 ? "R8 no sleep" : "R7 no sleep", {busy, clk_run, cur_state}, 7);
        end
        wfi = 1'b0; mode = 2'd3;

        // R10 running minimum and rearm.
        pulse_clear(1'b1, 1'b1, 1'b1);
        do_sleep(2'd1, 1'b1);
        do_wake(0);
        do_sleep(2'd2, 1'b0);
        chk("R10 min kept", lps, 1);
        do_wake(1);
        pulse_clear(1'b0, 1'b0, 1'b1);
        chk("R10 rearm", lps, 3);
        do_sleep(2'd2, 1'b0);
        chk("R10 new entry", lps, 2);
        do_wake(2);

        // R12 warm and software reset while in retention.
        pulse_clear(1'b1, 1'b1, 1'b1);
        do_sleep(2'd1, 1'b1);
        chk("R12 dff clear before", dff_lost, 0);
        warm_rst_n = 1'b0;
        @(negedge clk);
        chk("R12 core reset warm", core_rst, 1);
        @(negedge clk);
        warm_rst_n = 1'b1;
        @(negedge clk);
        chk("R12 core reset released", core_rst, 0);
        chk("R12 dff set", dff_lost, 1);
        chk("R12 state kept", cur_state, 1);
        chk("R12 l1 kept", l1_state, 1);
        chk("R12 lps kept", lps, 1);
        chk("R12 l1 lost kept", l1_lost, 0);
        sw_rst = 1'b1;
        @(negedge clk);
        chk("R12 core reset sw", core_rst, 1);
        pulse_clear(1'b0, 1'b1, 1'b0);
        chk("R11 set wins over clear", dff_lost, 1);
        sw_rst = 1'b0;
        pulse_clear(1'b0, 1'b1, 1'b0);
        chk("R11 clear after reset", dff_lost, 0);
        chk("R12 sw released", core_rst, 0);
        do_wake(0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule